// File: doc/BRIEF.md
# Flow-Controlled Serial Transmitter with Modem Status Interrupt

This block sends bytes as asynchronous serial frames: one low start bit, eight data bits with the least significant bit first, and one high stop bit. Every bit lasts sixteen pulses of a baud-rate tick input. The byte comes in through a valid/ready handshake, and the serial line idles high.

When automatic flow control is turned on, each new frame may begin only while the active-low clear-to-send input is asserted. The decision for a frame that follows directly behind another is taken at the middle of the earlier frame's stop bit. The peer must therefore withdraw clear-to-send before that point to hold the next byte back.

The block also watches four active-low modem lines: clear-to-send, carrier detect, data-set-ready and ring indicator. Each line passes through a two-flop synchroniser. The block keeps a sticky change flag for each line, and a status-read strobe clears the flags. From these flags it forms one modem-status interrupt. The clear-to-send flag can be masked out of the interrupt while flow control is automatic.

Top module: `cts_uart_tx`

## Requirements
- R1: A frame is a 0 start bit, eight data bits LSB first, and a 1 stop bit. Each bit lasts 16 `baud_tick` pulses, and `txd` is 1 whenever no frame is being sent.
- R2: A byte is taken on a cycle with `tx_valid` and `tx_ready` both high, and its start bit appears on the next cycle. `tx_ready` stays low until the stop bit ends. A waiting byte then starts within a few cycles, so frames run back to back.
- R3: With `auto_cts_en` at 0, `cts_n` has no effect on when frames start.
- R4: With `auto_cts_en` at 1, a frame starts from idle only while the synchronised `cts_n` is 0. A byte held back by a high `cts_n` starts within a few cycles after `cts_n` falls.
- R5: With `auto_cts_en` at 1, `cts_n` is sampled at the middle of each stop bit (the 8th tick of 16). If it is 1 there, the next byte waits at least one further bit time after the stop bit ends, even if `cts_n` falls again in the meantime. If it is 0 there, the next byte starts back to back, even if `cts_n` rises after the midpoint.
- R6: `modem_delta` bit 0 (CTS), bit 1 (DSR) and bit 3 (DCD) are set on any change of the synchronised line. Bit 2 is set when `ri_n` goes from 0 to 1. The CTS flag is set whatever the value of `auto_cts_en`.
- R7: `status_rd` clears all `modem_delta` bits. A change that lands in the same cycle as the read leaves its bit set. With no read, a set bit stays set.
- R8: With `modem_irq_en` at 0, `modem_irq` is 0.
- R9: With `modem_irq_en` at 1 and `auto_cts_en` at 0, `modem_irq` is 1 exactly when any `modem_delta` bit is set.
- R10: With `modem_irq_en` at 1 and `auto_cts_en` at 1, the CTS flag raises `modem_irq` only when `cts_irq_en` is 1. The DSR, RI and DCD flags raise it regardless.
- R11: After reset, `txd` is 1, `modem_delta` is 0, `modem_irq` is 0, and `tx_ready` is 1 while `auto_cts_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmitter can take a byte this cycle |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready, active low, asynchronous |
| ri_n | input | 1 | Ring indicator, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect, active low, asynchronous |
| auto_cts_en | input | 1 | Gate frame starts on clear-to-send |
| modem_irq_en | input | 1 | Master enable for the modem-status interrupt |
| cts_irq_en | input | 1 | Lets the CTS flag interrupt while flow control is automatic |
| status_rd | input | 1 | Read strobe that clears the change flags |
| txd | output | 1 | Serial output line |
| modem_delta | output | 4 | Change flags: 0 CTS, 1 DSR, 2 RI trailing edge, 3 DCD |
| modem_irq | output | 1 | Modem-status interrupt |

## Verification
The assertions check, on every cycle, the properties that hold locally in time. A start bit follows each accepted byte, and the line never moves between baud ticks. No frame leaves idle while clear-to-send is high under flow control, outside the post-frame window. Change flags stay set until a read, a synchronised CTS change always sets its flag, and the interrupt masks hold. Only the bench scenarios can show the rest: the bit order and frame length, the gap between frames when clear-to-send is withdrawn just before or just after the stop-bit midpoint, the latency from a released clear-to-send to the start bit, and a read that collides with an edge in the same cycle.

// File: rtl/cts_uart_pkg.sv
package cts_uart_pkg;

    // Bit positions of the modem change flags
    localparam int MDM_CTS   = 0;
    localparam int MDM_DSR   = 1;
    localparam int MDM_RI    = 2;
    localparam int MDM_DCD   = 3;
    localparam int MDM_LINES = 4;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;

endpackage

// File: rtl/cts_uart_sync.sv
module cts_uart_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/cts_uart_tx_engine.sv
module cts_uart_tx_engine
    import cts_uart_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int BIT_TICKS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 baud_tick,
    input  logic [DATA_BITS-1:0] tx_data,
    input  logic                 tx_valid,
    output logic                 tx_ready,
    input  logic                 auto_cts_en,
    input  logic                 cts_sync_n,
    output logic                 txd
);

    localparam int TICK_W    = $clog2(BIT_TICKS);
    localparam int BIT_W     = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam int MID_TICK  = BIT_TICKS / 2 - 1;
    localparam int LAST_TICK = BIT_TICKS - 1;

    typedef struct packed {
        tx_state_e             state;
        logic [TICK_W-1:0]     tick;
        logic [BIT_W-1:0]      bitn;
        logic [DATA_BITS-1:0]  shreg;
        logic                  go;    // CTS verdict taken at stop midpoint
        logic                  win;   // post-frame window governed by go
        logic                  txd;
    } tx_regs_t;

    tx_regs_t rq, rd;
    logic     accept;
    logic     last_tick;

    assign tx_ready  = (rq.state == TX_IDLE) &&
                       (!auto_cts_en || (rq.win ? rq.go : !cts_sync_n));
    assign accept    = tx_valid && tx_ready;
    assign last_tick = baud_tick && (rq.tick == TICK_W'(LAST_TICK));

    always_comb begin
        rd = rq;
        if (baud_tick) begin
            rd.tick = last_tick ? '0 : rq.tick + 1'b1;
        end
        unique case (rq.state)
            TX_IDLE: begin
                if (accept) begin
                    rd.state = TX_START;
                    rd.tick  = '0;
                    rd.shreg = tx_data;
                    rd.win   = 1'b0;
                end else if (rq.win && last_tick) begin
                    rd.win = 1'b0;
                end
            end
            TX_START: begin
                if (last_tick) begin
                    rd.state = TX_DATA;
                    rd.bitn  = '0;
                end
            end
            TX_DATA: begin
                if (last_tick) begin
                    rd.shreg = rq.shreg >> 1;
                    if (rq.bitn == BIT_W'(DATA_BITS - 1)) begin
                        rd.state = TX_STOP;
                    end else begin
                        rd.bitn = rq.bitn + 1'b1;
                    end
                end
            end
            TX_STOP: begin
                if (baud_tick && (rq.tick == TICK_W'(MID_TICK))) begin
                    rd.go = !cts_sync_n;
                end
                if (last_tick) begin
                    rd.state = TX_IDLE;
                    rd.win   = auto_cts_en;
                end
            end
            default: rd.state = TX_IDLE;
        endcase
        unique case (rd.state)
            TX_START: rd.txd = 1'b0;
            TX_DATA:  rd.txd = rd.shreg[0];
            default:  rd.txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq.state <= TX_IDLE;
            rq.tick  <= '0;
            rq.bitn  <= '0;
            rq.shreg <= '0;
            rq.go    <= 1'b0;
            rq.win   <= 1'b0;
            rq.txd   <= 1'b1;
        end else begin
            rq <= rd;
        end
    end

    assign txd = rq.txd;

    // R2
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !txd);

    // R1
    txd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick && !(tx_valid && tx_ready)) |=> $stable(txd));

    // R4
    no_start_cts_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_cts_en && cts_sync_n && rq.state == TX_IDLE && !rq.win) |=> txd);

endmodule

// File: rtl/cts_uart_modem_status.sv
module cts_uart_modem_status
    import cts_uart_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cts_n,
    input  logic                 dsr_n,
    input  logic                 ri_n,
    input  logic                 dcd_n,
    input  logic                 status_rd,
    input  logic                 auto_cts_en,
    input  logic                 modem_irq_en,
    input  logic                 cts_irq_en,
    output logic                 cts_sync_n,
    output logic [MDM_LINES-1:0] modem_delta,
    output logic                 modem_irq
);

    typedef struct packed {
        logic [MDM_LINES-1:0] prev;
        logic [MDM_LINES-1:0] delta;
    } mdm_regs_t;

    mdm_regs_t            mq, md;
    logic [MDM_LINES-1:0] raw_vec, sync_vec, chg, ev, irq_mask;

    always_comb begin
        raw_vec          = '1;
        raw_vec[MDM_CTS] = cts_n;
        raw_vec[MDM_DSR] = dsr_n;
        raw_vec[MDM_RI]  = ri_n;
        raw_vec[MDM_DCD] = dcd_n;
    end

    cts_uart_sync #(
        .WIDTH   (MDM_LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({MDM_LINES{1'b1}})
    ) line_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_vec),
        .sync_o  (sync_vec)
    );

    always_comb begin
        chg         = sync_vec ^ mq.prev;
        ev          = chg;
        ev[MDM_RI]  = chg[MDM_RI] & sync_vec[MDM_RI];
        md.prev     = sync_vec;
        md.delta    = (status_rd ? '0 : mq.delta) | ev;

        irq_mask          = '1;
        irq_mask[MDM_CTS] = !auto_cts_en || cts_irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mq.prev  <= '1;
            mq.delta <= '0;
        end else begin
            mq <= md;
        end
    end

    assign cts_sync_n  = sync_vec[MDM_CTS];
    assign modem_delta = mq.delta;
    assign modem_irq   = modem_irq_en && |(mq.delta & irq_mask);

    // R7
    delta_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status_rd |=> ((modem_delta & $past(modem_delta)) == $past(modem_delta)));

    // R6
    cts_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_sync_n != $past(cts_sync_n)) |=> modem_delta[MDM_CTS]);

    // R8
    irq_master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !modem_irq_en |-> !modem_irq);

    // R10
    cts_masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_cts_en && !cts_irq_en && !modem_delta[MDM_DSR] &&
         !modem_delta[MDM_RI] && !modem_delta[MDM_DCD]) |-> !modem_irq);

endmodule

// File: rtl/cts_uart_tx.sv
module cts_uart_tx
    import cts_uart_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int BIT_TICKS   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 baud_tick,
    input  logic [DATA_BITS-1:0] tx_data,
    input  logic                 tx_valid,
    output logic                 tx_ready,
    input  logic                 cts_n,
    input  logic                 dsr_n,
    input  logic                 ri_n,
    input  logic                 dcd_n,
    input  logic                 auto_cts_en,
    input  logic                 modem_irq_en,
    input  logic                 cts_irq_en,
    input  logic                 status_rd,
    output logic                 txd,
    output logic [MDM_LINES-1:0] modem_delta,
    output logic                 modem_irq
);

    logic cts_sync_n;

    cts_uart_modem_status #(
        .SYNC_STAGES (SYNC_STAGES)
    ) mdm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cts_n        (cts_n),
        .dsr_n        (dsr_n),
        .ri_n         (ri_n),
        .dcd_n        (dcd_n),
        .status_rd    (status_rd),
        .auto_cts_en  (auto_cts_en),
        .modem_irq_en (modem_irq_en),
        .cts_irq_en   (cts_irq_en),
        .cts_sync_n   (cts_sync_n),
        .modem_delta  (modem_delta),
        .modem_irq    (modem_irq)
    );

    cts_uart_tx_engine #(
        .DATA_BITS (DATA_BITS),
        .BIT_TICKS (BIT_TICKS)
    ) tx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .baud_tick   (baud_tick),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .auto_cts_en (auto_cts_en),
        .cts_sync_n  (cts_sync_n),
        .txd         (txd)
    );

endmodule

// File: tb/cts_uart_tx_tb_top.sv
module cts_uart_tx_tb_top;

    localparam int BIT_CLK   = 32;           // 16 ticks, one tick every 2 clocks
    localparam int FRAME_CLK = 10 * BIT_CLK;

    logic       clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0, tx_ready;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic       auto_cts_en = 1'b0, modem_irq_en = 1'b0, cts_irq_en = 1'b0, status_rd = 1'b0;
    logic       txd, modem_irq;
    logic [3:0] modem_delta;

    int         checks = 0, errors = 0;
    longint     cyc = 0;
    int         rx_n = 0, sent_n = 0;
    logic [7:0] rx_byte [64];
    longint     rx_t [64];
    logic [7:0] exp_b [64];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) baud_tick <= rst_n ? ~baud_tick : 1'b0;

    cts_uart_tx dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
        .auto_cts_en(auto_cts_en), .modem_irq_en(modem_irq_en),
        .cts_irq_en(cts_irq_en), .status_rd(status_rd),
        .txd(txd), .modem_delta(modem_delta), .modem_irq(modem_irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_irq(input bit en, input bit auto_on, input bit ctsie,
                                   input logic [3:0] d);
        return en && ((d[0] && (!auto_on || ctsie)) || d[1] || d[2] || d[3]);
    endfunction

    // Line monitor: decodes frames at bit centres
    initial begin
        longint     t0;
        logic [7:0] b;
        bit         ok;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (txd === 1'b0) begin
                t0 = cyc;
                repeat (BIT_CLK / 2) @(negedge clk);
                ok = (txd === 1'b0);
                for (int k = 0; k < 8; k++) begin
                    repeat (BIT_CLK) @(negedge clk);
                    b[k] = txd;
                end
                repeat (BIT_CLK) @(negedge clk);
                ok = ok && (txd === 1'b1);
                chk(ok, "R1", "start/stop framing", ok, 1);
                if (rx_n < 64) begin
                    rx_byte[rx_n] = b;
                    rx_t[rx_n]    = t0;
                end
                rx_n++;
            end
        end
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        tx_data  = b;
        tx_valid = 1'b1;
        exp_b[sent_n] = b;
        sent_n++;
        while (!tx_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic release_tx();
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        while (rx_n < n) @(negedge clk);
    endtask

    task automatic check_bytes(input int from, input int to, input string req);
        for (int i = from; i < to; i++) begin
            chk(rx_byte[i] == exp_b[i], req, "received byte", rx_byte[i], exp_b[i]);
        end
    endtask

    task automatic read_status();
        @(negedge clk) status_rd = 1'b1;
        @(negedge clk) status_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WD", "watchdog expired", cyc, 150000);
        report();
    end

    initial begin
        int         base;
        longint     tcts;
        logic [3:0] flip, exp_d;
        bit         en, au, ci;

        void'($urandom(32'd5113));
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R11 reset state
        chk(txd === 1'b1, "R11", "txd after reset", txd, 1);
        chk(modem_delta === 4'd0, "R11", "delta after reset", modem_delta, 0);
        chk(modem_irq === 1'b0, "R11", "irq after reset", modem_irq, 0);
        chk(tx_ready === 1'b1, "R11", "ready after reset", tx_ready, 1);

        // R1, R2, R3: CTS held inactive, flow control off, back-to-back frames
        read_status();
        cts_n = 1'b1;
        base = rx_n;
        send_byte(8'h00);
        @(negedge clk);
        chk(tx_ready === 1'b0, "R2", "ready low during frame", tx_ready, 0);
        send_byte(8'hFF);
        send_byte(8'hA5);
        for (int i = 0; i < 4; i++) send_byte(8'($urandom));
        release_tx();
        wait_rx(base + 7);
        check_bytes(base, base + 7, "R1");
        for (int i = base; i < base + 6; i++) begin
            chk(rx_t[i+1] - rx_t[i] >= FRAME_CLK, "R1", "frame period floor",
                rx_t[i+1] - rx_t[i], FRAME_CLK);
            chk(rx_t[i+1] - rx_t[i] <= FRAME_CLK + 6, "R3", "back-to-back with CTS high",
                rx_t[i+1] - rx_t[i], FRAME_CLK);
        end

        // R4: flow control on, CTS high holds a pending byte
        auto_cts_en = 1'b1;
        base = rx_n;
        tcts = 0;
        fork
            send_byte(8'h3C);
            begin
                repeat (300) @(negedge clk);
                chk(tx_ready === 1'b0, "R4", "ready while CTS high", tx_ready, 0);
                chk(rx_n == base, "R4", "no frame while CTS high", rx_n, base);
                tcts  = cyc;
                cts_n = 1'b0;
            end
        join
        release_tx();
        wait_rx(base + 1);
        check_bytes(base, base + 1, "R4");
        chk(rx_t[base] - tcts <= 6, "R4", "start latency after CTS low",
            rx_t[base] - tcts, 4);

        // R5: CTS withdrawn before the stop midpoint, back low before stop end
        base = rx_n;
        fork
            begin send_byte(8'h5A); send_byte(8'hC3); end
            begin
                @(negedge clk);
                while (txd !== 1'b0) @(negedge clk);
                repeat (9 * BIT_CLK + 8) @(negedge clk);
                cts_n = 1'b1;
                repeat (16) @(negedge clk);
                cts_n = 1'b0;
            end
        join
        release_tx();
        wait_rx(base + 2);
        check_bytes(base, base + 2, "R5");
        chk(rx_t[base+1] - rx_t[base] >= FRAME_CLK + BIT_CLK, "R5", "held one bit after early CTS",
            rx_t[base+1] - rx_t[base], FRAME_CLK + BIT_CLK);
        chk(rx_t[base+1] - rx_t[base] <= FRAME_CLK + BIT_CLK + 8, "R5", "resumes after window",
            rx_t[base+1] - rx_t[base], FRAME_CLK + BIT_CLK);

        // R5: CTS withdrawn after the stop midpoint does not hold the next byte
        base = rx_n;
        fork
            begin send_byte(8'h81); send_byte(8'h7E); end
            begin
                @(negedge clk);
                while (txd !== 1'b0) @(negedge clk);
                repeat (9 * BIT_CLK + 24) @(negedge clk);
                cts_n = 1'b1;
                repeat (36) @(negedge clk);
                cts_n = 1'b0;
            end
        join
        release_tx();
        wait_rx(base + 2);
        check_bytes(base, base + 2, "R5");
        chk(rx_t[base+1] - rx_t[base] <= FRAME_CLK + 6, "R5", "late CTS keeps back-to-back",
            rx_t[base+1] - rx_t[base], FRAME_CLK);

        // R6, R9, R7: DCD change with flow control off
        repeat (BIT_CLK * 2) @(negedge clk);
        auto_cts_en = 1'b0; modem_irq_en = 1'b1; cts_irq_en = 1'b0;
        settle(); read_status();
        dcd_n = 1'b0; settle();
        chk(modem_delta === 4'b1000, "R6", "DCD flag", modem_delta, 4'b1000);
        chk(modem_irq === 1'b1, "R9", "irq from DCD", modem_irq, 1);
        read_status();
        chk(modem_delta === 4'b0000, "R7", "read clears", modem_delta, 0);
        chk(modem_irq === 1'b0, "R9", "irq after clear", modem_irq, 0);

        // R6, R10: CTS flag under flow control
        auto_cts_en = 1'b1;
        cts_n = 1'b1; settle();
        chk(modem_delta === 4'b0001, "R6", "CTS flag with auto on", modem_delta, 1);
        chk(modem_irq === 1'b0, "R10", "CTS masked", modem_irq, 0);
        cts_irq_en = 1'b1; @(negedge clk);
        chk(modem_irq === 1'b1, "R10", "CTS unmasked", modem_irq, 1);
        cts_irq_en = 1'b0; read_status();
        dsr_n = 1'b0; settle();
        chk(modem_irq === 1'b1, "R10", "DSR raises irq with auto on", modem_irq, 1);

        // R6: RI leading edge ignored, trailing edge flagged
        read_status();
        ri_n = 1'b0; settle();
        chk(modem_delta === 4'b0000, "R6", "RI leading edge", modem_delta, 0);
        ri_n = 1'b1; settle();
        chk(modem_delta === 4'b0100, "R6", "RI trailing edge", modem_delta, 4'b0100);

        // R7: read colliding with an edge keeps the flag
        read_status();
        chk(modem_delta === 4'b0000, "R7", "cleared before collision", modem_delta, 0);
        @(negedge clk) dsr_n = ~dsr_n;
        @(negedge clk);
        @(negedge clk) status_rd = 1'b1;
        @(negedge clk) status_rd = 1'b0;
        chk(modem_delta === 4'b0010, "R7", "edge wins over read", modem_delta, 4'b0010);

        // R8: master enable off
        modem_irq_en = 1'b0;
        dcd_n = ~dcd_n; cts_n = ~cts_n; settle();
        chk(modem_irq === 1'b0, "R8", "irq with master off", modem_irq, 0);

        // Random modem line changes against the interrupt rule
        cts_n = 1'b0; settle();
        for (int it = 0; it < 40; it++) begin
            en = 1'($urandom); au = 1'($urandom); ci = 1'($urandom);
            modem_irq_en = en; auto_cts_en = au; cts_irq_en = ci;
            read_status();
            flip = 4'($urandom);
            @(negedge clk);
            exp_d = '0;
            if (flip[0]) begin cts_n = ~cts_n; exp_d[0] = 1'b1; end
            if (flip[1]) begin dsr_n = ~dsr_n; exp_d[1] = 1'b1; end
            if (flip[2]) begin ri_n  = ~ri_n;  exp_d[2] = ri_n;  end
            if (flip[3]) begin dcd_n = ~dcd_n; exp_d[3] = 1'b1; end
            settle();
            chk(modem_delta === exp_d, "R6", "random flags", modem_delta, exp_d);
            chk(modem_irq === exp_irq(en, au, ci, exp_d), "R9", "random irq (R8 R10)",
                modem_irq, exp_irq(en, au, ci, exp_d));
        end

        report();
    end

endmodule